// File: doc/BRIEF.md
# Iterative Dual-Mode CORDIC Engine

This block evaluates circular-coordinate CORDIC on 32-bit two's-complement fixed-point operands, one micro-rotation per clock. A single pulse on `start` captures three initial values and a mode bit. Thirty-two clock cycles later the engine raises `done` for one cycle and presents the final x, y and z accumulators. In rotation mode it turns the vector (x0, y0) by the angle z0, which yields scaled cosine and sine. In vectoring mode it turns (x0, y0) onto the positive x axis. This yields the scaled magnitude in x and the angle of the vector in z.

Angles are expressed in degrees multiplied by 8,000,000. The engine applies no gain correction. Every result in x and y carries the product An = prod(sqrt(1 + 4^-i)) over the 32 steps, about 1.6468. A caller that needs unscaled results compensates x0 and y0 before starting. Rotation and vectoring share one datapath. They differ only in which sign bit drives the per-step direction, and that one decision steers all three add/subtract units together.

Top module: `cordic_engine`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the engine returns to idle, `done` goes low and `x_res`, `y_res`, `z_res` become 0.
- R2: A `start` sampled high at rising edge N while idle loads `x_init`, `y_init`, `z_init` and `mode`. Exactly 32 micro-rotations then follow, one per edge. `done` is low after edge N+31 and high after edge N+32.
- R3: Step i (i = 0..31), with d = +1 or -1, computes x' = x - d*(y >>> i), y' = y + d*(x >>> i) and z' = z - d*T[i]. All three use the pre-step x and y, the shifts are arithmetic, and the sums wrap at 32 bits.
- R4: With `mode` = 0 (rotation), d = +1 when z >= 0 and d = -1 when z < 0 (sign bit 31 of z).
- R5: With `mode` = 1 (vectoring), d = +1 when y < 0 and d = -1 when y >= 0 (sign bit 31 of y).
- R6: T[i] equals atan(2^-i) in degrees times 8,000,000, rounded to the nearest integer. T[0] is 360,000,000, and T[30] and T[31] are 0.
- R7: In rotation mode with |z0| <= 720,000,000 (90 degrees), the results approach An*(x0*cos z0 - y0*sin z0) in x and An*(y0*cos z0 + x0*sin z0) in y, and z approaches 0.
- R8: In vectoring mode with x0 >= 0, the results approach An*sqrt(x0^2 + y0^2) in x and 0 in y. z approaches atan2(y0, x0) in degrees times 8,000,000.
- R9: `done` is high for exactly one cycle. The three results keep their values from then until the next accepted start, whatever the inputs do.
- R10: A `start` during the 32 running cycles, or in the cycle in which `done` is high, is ignored. It neither restarts nor shortens the operation and loads nothing.
- R11: `mode` and the initial values are used only at the accepted start. Changes to them during the operation have no effect on its results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request a new operation; accepted only when idle |
| mode | input | 1 | 0 = rotation, 1 = vectoring; captured at start |
| x_init | input | 32 | Initial x, signed |
| y_init | input | 32 | Initial y, signed |
| z_init | input | 32 | Initial z angle, signed, degrees x 8,000,000 |
| done | output | 1 | One-cycle completion pulse |
| x_res | output | 32 | x accumulator, signed |
| y_res | output | 32 | y accumulator, signed |
| z_res | output | 32 | z accumulator, signed |

## Verification
The bench raises `start` before the rising edge N at which it is accepted. After edge N+31 it confirms that `done` is still low. After edge N+32 it requires `done` high and checks all three results in that same cycle. Every sample is taken on the falling edge, so each check sits half a period after the register update it observes. Results are compared exactly with a step-by-step model that the bench builds from the update equations, using its own angle table computed from `$atan`, and they are also compared within a tolerance with the ideal trigonometric values. Starts injected mid-run or in the `done` cycle are followed by checks at the original completion edge and for 40 cycles afterwards.

// File: rtl/cordic_pkg.sv
// Shared definitions for the CORDIC engine.
// Holds the controller state encoding, the mode encoding and the
// elementary-angle table (degrees x 8,000,000, rounded), valid for
// step indices 0..31.
package cordic_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } cordic_state_e;

    localparam logic MODE_ROTATE = 1'b0;
    localparam logic MODE_VECTOR = 1'b1;

    // Elementary angle atan(2^-idx) in degrees scaled by 8e6.
    function automatic logic [31:0] atan_step_deg8m(input logic [4:0] idx);
        case (idx)
            5'd0:  return 32'd360000000;
            5'd1:  return 32'd212520409;
            5'd2:  return 32'd112289948;
            5'd3:  return 32'd57000131;
            5'd4:  return 32'd28610675;
            5'd5:  return 32'd14319285;
            5'd6:  return 32'd7161390;
            5'd7:  return 32'd3580913;
            5'd8:  return 32'd1790484;
            5'd9:  return 32'd895245;
            5'd10: return 32'd447623;
            5'd11: return 32'd223812;
            5'd12: return 32'd111906;
            5'd13: return 32'd55953;
            5'd14: return 32'd27976;
            5'd15: return 32'd13988;
            5'd16: return 32'd6994;
            5'd17: return 32'd3497;
            5'd18: return 32'd1749;
            5'd19: return 32'd874;
            5'd20: return 32'd437;
            5'd21: return 32'd219;
            5'd22: return 32'd109;
            5'd23: return 32'd55;
            5'd24: return 32'd27;
            5'd25: return 32'd14;
            5'd26: return 32'd7;
            5'd27: return 32'd3;
            5'd28: return 32'd2;
            5'd29: return 32'd1;
            5'd30: return 32'd0;
            5'd31: return 32'd0;
        endcase
    endfunction

endpackage

// File: rtl/cordic_shift.sv
// Logarithmic arithmetic right shifter.
// One mux stage per bit of the shift amount; stage s shifts by 2^s.
// Assumes amt < W; the sign bit is replicated into vacated positions.
module cordic_shift #(
    parameter int W    = 32,
    parameter int SH_W = $clog2(W)
) (
    input  logic signed [W-1:0]    din,
    input  logic        [SH_W-1:0] amt,
    output logic signed [W-1:0]    dout
);

    logic signed [W-1:0] stage [0:SH_W];

    assign stage[0] = din;

    // Each stage conditionally shifts by its own power of two.
    for (genvar s = 0; s < SH_W; s++) begin : g_stage
        assign stage[s+1] = amt[s] ? (stage[s] >>> (2 ** s)) : stage[s];
    end

    assign dout = stage[SH_W];

endmodule

// File: rtl/cordic_addsub.sv
// Two's-complement adder/subtractor with wrap-around.
// sub = 1 gives a - b, sub = 0 gives a + b. No saturation.
module cordic_addsub #(
    parameter int W = 32
) (
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic                sub,
    output logic signed [W-1:0] sum
);

    // Select operation by the shared direction control.
    always_comb begin
        if (sub) sum = a - b;
        else     sum = a + b;
    end

endmodule

// File: rtl/cordic_dir.sv
// Per-step rotation direction decision.
// Output pos_step = 1 means d = +1. Rotation mode follows the z sign
// (non-negative z -> +1); vectoring mode follows the y sign
// (negative y -> +1). Pure combinational, two sign bits and the mode.
module cordic_dir (
    input  logic vector_mode,
    input  logic y_neg,
    input  logic z_neg,
    output logic pos_step
);

    // Pick which sign bit drives the step direction.
    always_comb begin
        if (vector_mode) pos_step = y_neg;
        else             pos_step = ~z_neg;
    end

endmodule

// File: rtl/cordic_ctrl.sv
// Iteration controller: IDLE -> RUN (ITER cycles) -> DONE (1 cycle) -> IDLE.
// Accepts start only in IDLE. step_idx counts 0..ITER-1 during RUN.
// Assumes ITER >= 2. Synchronous active-low reset.
module cordic_ctrl
    import cordic_pkg::*;
#(
    parameter int ITER  = 32,
    parameter int CNT_W = $clog2(ITER)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             run,
    output logic [CNT_W-1:0] step_idx,
    output logic             done
);

    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ITER - 1);

    cordic_state_e    state_q;
    logic [CNT_W-1:0] cnt_q;

    // State and step counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= '0;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == LAST_IDX) state_q <= ST_DONE;
                    else                   cnt_q   <= cnt_q + 1'b1;
                end
                ST_DONE: state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Decoded controls for the datapath.
    always_comb begin
        load     = (state_q == ST_IDLE) && start;
        run      = (state_q == ST_RUN);
        done     = (state_q == ST_DONE);
        step_idx = cnt_q;
    end

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_run_not_restarted_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (run && cnt_q != LAST_IDX) |=> (run && cnt_q == $past(cnt_q) + 1'b1));

    assert_done_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (state_q == ST_IDLE));

endmodule

// File: rtl/cordic_engine.sv
// Iterative circular CORDIC engine, one micro-rotation per clock.
// Loads x/y/z and mode on an accepted start, runs ITER steps, then
// pulses done and holds the accumulators. No gain compensation.
// Assumes ITER <= 32 (angle table size) and DATA_W >= 32.
module cordic_engine
    import cordic_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ITER   = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     start,
    input  logic                     mode,
    input  logic signed [DATA_W-1:0] x_init,
    input  logic signed [DATA_W-1:0] y_init,
    input  logic signed [DATA_W-1:0] z_init,
    output logic                     done,
    output logic signed [DATA_W-1:0] x_res,
    output logic signed [DATA_W-1:0] y_res,
    output logic signed [DATA_W-1:0] z_res
);

    localparam int CNT_W = $clog2(ITER);
    localparam int SH_W  = $clog2(DATA_W);

    logic                     load;
    logic                     run;
    logic [CNT_W-1:0]         step_idx;
    logic                     mode_q;
    logic                     pos_step;
    logic signed [DATA_W-1:0] x_q, y_q, z_q;
    logic signed [DATA_W-1:0] x_sh, y_sh, ang;
    logic signed [DATA_W-1:0] x_nxt, y_nxt, z_nxt;
    logic [SH_W-1:0]          sh_amt;

    cordic_ctrl #(.ITER(ITER), .CNT_W(CNT_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load     (load),
        .run      (run),
        .step_idx (step_idx),
        .done     (done)
    );

    cordic_dir u_dir (
        .vector_mode (mode_q),
        .y_neg       (y_q[DATA_W-1]),
        .z_neg       (z_q[DATA_W-1]),
        .pos_step    (pos_step)
    );

    // Shift amount and elementary angle for the current step.
    always_comb begin
        sh_amt = SH_W'(step_idx);
        ang    = DATA_W'(atan_step_deg8m(5'(step_idx)));
    end

    cordic_shift #(.W(DATA_W), .SH_W(SH_W)) u_shift_x (
        .din  (x_q),
        .amt  (sh_amt),
        .dout (x_sh)
    );

    cordic_shift #(.W(DATA_W), .SH_W(SH_W)) u_shift_y (
        .din  (y_q),
        .amt  (sh_amt),
        .dout (y_sh)
    );

    cordic_addsub #(.W(DATA_W)) u_add_x (
        .a   (x_q),
        .b   (y_sh),
        .sub (pos_step),
        .sum (x_nxt)
    );

    cordic_addsub #(.W(DATA_W)) u_add_y (
        .a   (y_q),
        .b   (x_sh),
        .sub (~pos_step),
        .sum (y_nxt)
    );

    cordic_addsub #(.W(DATA_W)) u_add_z (
        .a   (z_q),
        .b   (ang),
        .sub (pos_step),
        .sum (z_nxt)
    );

    // Accumulator registers: load on start, step while running, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_q    <= '0;
            y_q    <= '0;
            z_q    <= '0;
            mode_q <= MODE_ROTATE;
        end else if (load) begin
            x_q    <= x_init;
            y_q    <= y_init;
            z_q    <= z_init;
            mode_q <= mode;
        end else if (run) begin
            x_q    <= x_nxt;
            y_q    <= y_nxt;
            z_q    <= z_nxt;
        end
    end

    always_comb begin
        x_res = x_q;
        y_res = y_q;
        z_res = z_q;
    end

    // Checker: cycles spent running since the last accepted start.
    logic [CNT_W:0] run_len_q;
    always_ff @(posedge clk) begin
        if (!rst_n)    run_len_q <= '0;
        else if (load) run_len_q <= '0;
        else if (run)  run_len_q <= run_len_q + 1'b1;
    end

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (run_len_q == (CNT_W+1)'(ITER)));

    assert_rot_pos_z_falls_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_q == MODE_ROTATE && !z_q[DATA_W-1]) |=> (z_q <= $past(z_q)));

    assert_rot_neg_z_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_q == MODE_ROTATE && z_q[DATA_W-1]) |=> (z_q >= $past(z_q)));

    assert_vec_pos_y_z_rises_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_q == MODE_VECTOR && !y_q[DATA_W-1]) |=> (z_q >= $past(z_q)));

    assert_vec_neg_y_z_falls_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && mode_q == MODE_VECTOR && y_q[DATA_W-1]) |=> (z_q <= $past(z_q)));

    assert_results_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !load) |=> ($stable(x_res) && $stable(y_res) && $stable(z_res)));

endmodule

// File: tb/cordic_engine_test.sv
// Directed bench for cordic_engine: one task per scenario.
module cordic_engine_test;

    localparam real PI    = 3.14159265358979323846;
    localparam real SCALE = 8000000.0;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic               rst_n = 1'b0;
    logic               start = 1'b0;
    logic               mode  = 1'b0;
    logic signed [31:0] x_init = '0, y_init = '0, z_init = '0;
    logic               done;
    logic signed [31:0] x_res, y_res, z_res;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  tab [32];
    real gain;

    cordic_engine uut (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .mode   (mode),
        .x_init (x_init),
        .y_init (y_init),
        .z_init (z_init),
        .done   (done),
        .x_res  (x_res),
        .y_res  (y_res),
        .z_res  (z_res)
    );

    task automatic check_eq(string req, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_near(string req, string what, longint act, real exp, real tol);
        real diff;
        n_checks++;
        diff = real'(act) - exp;
        if (diff < 0.0) diff = -diff;
        if (diff > tol) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0.1f (tol %0.1f)", req, what, act, exp, tol);
        end
    endtask

    // Step model built from R3..R6.
    task automatic model(input logic m, input int x0, input int y0, input int z0,
                         output int rx, output int ry, output int rz);
        logic signed [31:0] a, b, c, na, nb;
        logic pos;
        a = x0; b = y0; c = z0;
        for (int i = 0; i < 32; i++) begin
            pos = m ? b[31] : ~c[31];
            if (pos) begin
                na = a - (b >>> i);
                nb = b + (a >>> i);
                c  = c - tab[i];
            end else begin
                na = a + (b >>> i);
                nb = b - (a >>> i);
                c  = c + tab[i];
            end
            a = na; b = nb;
        end
        rx = a; ry = b; rz = c;
    endtask

    // Present operands and a one-cycle start; returns at the falling edge after acceptance.
    task automatic launch(input logic m, input int x0, input int y0, input int z0);
        @(negedge clk);
        mode = m; x_init = x0; y_init = y0; z_init = z0; start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
    endtask

    // Check done timing (R2) and exact results (R3) for an operation just launched.
    task automatic await_and_compare(input int ex, input int ey, input int ez);
        repeat (31) @(posedge clk);
        @(negedge clk);
        check_eq("R2", "done before step 32", longint'(done), 0);
        @(posedge clk);
        @(negedge clk);
        check_eq("R2", "done at step 32", longint'(done), 1);
        check_eq("R3", "x exact", longint'(x_res), longint'(ex));
        check_eq("R3", "y exact", longint'(y_res), longint'(ey));
        check_eq("R3", "z exact", longint'(z_res), longint'(ez));
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_eq("R1", "done in reset", longint'(done), 0);
        check_eq("R1", "x in reset", longint'(x_res), 0);
        check_eq("R1", "y in reset", longint'(y_res), 0);
        check_eq("R1", "z in reset", longint'(z_res), 0);
        rst_n = 1'b1;
    endtask

    task automatic test_rotation(input int x0, input int y0, input int z0);
        int ex, ey, ez;
        real t;
        model(1'b0, x0, y0, z0, ex, ey, ez);
        launch(1'b0, x0, y0, z0);
        await_and_compare(ex, ey, ez);
        t = real'(z0) / SCALE * PI / 180.0;
        check_near("R7 R4 R6", "rotation x", longint'(x_res),
                   gain * (real'(x0) * $cos(t) - real'(y0) * $sin(t)), 1000.0);
        check_near("R7 R4 R6", "rotation y", longint'(y_res),
                   gain * (real'(y0) * $cos(t) + real'(x0) * $sin(t)), 1000.0);
        check_near("R7", "rotation residual z", longint'(z_res), 0.0, 100.0);
    endtask

    task automatic test_vectoring(input int x0, input int y0);
        int ex, ey, ez;
        model(1'b1, x0, y0, 0, ex, ey, ez);
        launch(1'b1, x0, y0, 0);
        await_and_compare(ex, ey, ez);
        check_near("R8 R5 R6", "vectoring magnitude", longint'(x_res),
                   gain * $sqrt(real'(x0) * real'(x0) + real'(y0) * real'(y0)), 1000.0);
        check_near("R8", "vectoring residual y", longint'(y_res), 0.0, 1000.0);
        check_near("R8 R6", "vectoring angle", longint'(z_res),
                   $atan2(real'(y0), real'(x0)) * 180.0 / PI * SCALE, 200.0);
    endtask

    // R10: a second start during the run changes nothing.
    task automatic test_start_in_run();
        int ex, ey, ez;
        model(1'b0, 600000000, 0, 240000000, ex, ey, ez);
        launch(1'b0, 600000000, 0, 240000000);
        for (int cyc = 1; cyc <= 32; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            if (cyc == 10) begin
                start = 1'b1; mode = 1'b1;
                x_init = 123456789; y_init = -98765432; z_init = 5;
            end
            if (cyc == 11) start = 1'b0;
            if (cyc == 31) check_eq("R10", "done early after mid-run start", longint'(done), 0);
        end
        check_eq("R10", "done on original schedule", longint'(done), 1);
        check_eq("R10", "x unaffected by mid-run start", longint'(x_res), longint'(ex));
        check_eq("R10", "y unaffected by mid-run start", longint'(y_res), longint'(ey));
        check_eq("R10", "z unaffected by mid-run start", longint'(z_res), longint'(ez));
    endtask

    // R11: mode and operand pins changed right after the start have no effect.
    task automatic test_inputs_captured();
        int ex, ey, ez;
        model(1'b1, 400000000, 300000000, 0, ex, ey, ez);
        launch(1'b1, 400000000, 300000000, 0);
        mode = 1'b0; x_init = -5; y_init = 77; z_init = 720000000;
        await_and_compare(ex, ey, ez);
        check_eq("R11", "x with pins changed", longint'(x_res), longint'(ex));
        check_eq("R11", "z with mode flipped", longint'(z_res), longint'(ez));
    endtask

    // R9/R10: done lasts one cycle, a start in the done cycle is dropped, results hold.
    task automatic test_done_cycle();
        int ex, ey, ez;
        int seen;
        model(1'b0, 300000000, 200000000, 360000000, ex, ey, ez);
        launch(1'b0, 300000000, 200000000, 360000000);
        await_and_compare(ex, ey, ez);
        start = 1'b1; mode = 1'b1; x_init = 11; y_init = 22; z_init = 33;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        check_eq("R9", "done one cycle only", longint'(done), 0);
        seen = 0;
        for (int k = 0; k < 40; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (done) seen++;
        end
        check_eq("R10", "start in done cycle ignored", longint'(seen), 0);
        check_eq("R9", "x held", longint'(x_res), longint'(ex));
        check_eq("R9", "y held", longint'(y_res), longint'(ey));
        check_eq("R9", "z held", longint'(z_res), longint'(ez));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        gain = 1.0;
        for (int i = 0; i < 32; i++) begin
            tab[i] = $rtoi($atan(2.0 ** (-i)) * 180.0 / PI * SCALE + 0.5);
            gain   = gain * $sqrt(1.0 + 4.0 ** (-i));
        end
        test_reset();
        test_rotation(600000000, 0, 240000000);
        test_rotation(600000000, 0, -480000000);
        test_rotation(600000000, 0, 720000000);
        test_rotation(600000000, 0, -720000000);
        test_rotation(300000000, 200000000, 360000000);
        test_rotation(500000000, -100000000, 0);
        test_vectoring(400000000, 300000000);
        test_vectoring(500000000, -200000000);
        test_vectoring(0, 500000000);
        test_vectoring(700000000, 0);
        test_start_in_run();
        test_inputs_captured();
        test_done_cycle();
        test_rotation(250000000, 250000000, -100000000);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule